// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block paces the instruction cycle of a small 16-bit accumulator machine. A 4-bit step counter advances on every rising clock edge and is decoded into sixteen one-hot step lines, T0 to T15. The first three steps carry every instruction's fetch and decode. In T0 the block asks for the program counter to be copied into the address register. In T1 it asks for the addressed memory word to be read into the instruction register and for the program counter to be incremented. In T2 it asks for the 12-bit address field to be copied into the address register. On the edge that ends T2 it also captures the opcode and the mode bit from the instruction register.

The opcode is bits 12 to 14 of the instruction. It passes through a 3-to-8 decoder, and the one-hot result is held, together with the mode bit (instruction bit 15), until the next decode step. Instruction phases have no fixed length. Any phase goes back to T0 when execute logic raises its clear request. Opcode 3 restarts automatically once it reaches T4. A counter that reaches T15 without a clear wraps to T0.

Only the control bits of the instruction word enter the block. The registers, memory and ALU that act on the strobes sit outside it.

Top module: `instr_timing_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the counter, the decoded opcode and the mode flag are cleared, so the next cycle shows `t_step` = 16'h0001, `op_dec` = 0 and `mode_i` = 0. All five strobe outputs stay low during every cycle in which `rst` is high.
- R2: With no clear condition, each rising edge advances the step by one. `t_step` always has exactly one bit set, and bit k marks step Tk.
- R3: From T15 with no clear condition, the next step is T0 (`t_step` = 16'h0001).
- R4: When `exec_clr` is high at an edge, the next step is T0, whatever the current step.
- R5: When `op_dec` bit 3 (opcode 3) is set during T4, the counter clears on that edge and the next step is T0. At T4 with any other opcode and no `exec_clr`, the next step is T5.
- R6: On the edge that ends T2, `op_dec` becomes the one-hot code of `ir_ctl[2:0]` (bit n set for opcode n) and `mode_i` takes `ir_ctl[3]`. Both outputs hold their values on every other edge that is not a reset edge.
- R7: `ld_ar_pc` is high only in T0. `rd_mem_ir` and `pc_incr` are high only in T1. `ld_ar_addr` is high only in T2. None of them is high while `rst` is high.
- R8: `seq_clear` is high exactly when `rst` is low and either `exec_clr` is high or the R5 condition holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ir_ctl | input | 4 | Instruction register bits 15..12: mode bit in bit 3, opcode in bits 2..0 |
| exec_clr | input | 1 | Restart request from execute logic |
| t_step | output | 16 | One-hot step lines T0..T15 |
| op_dec | output | 8 | One-hot decoded opcode D0..D7, held between decodes |
| mode_i | output | 1 | Captured addressing-mode bit |
| ld_ar_pc | output | 1 | Copy program counter to address register (T0) |
| rd_mem_ir | output | 1 | Read memory word into instruction register (T1) |
| pc_incr | output | 1 | Increment program counter (T1) |
| ld_ar_addr | output | 1 | Copy address field to address register (T2) |
| seq_clear | output | 1 | Step counter returns to T0 on the coming edge |

## Verification
The properties assume that `rst` is high from time zero until the first edges have passed. They place no limit on `ir_ctl` or `exec_clr`, because the block samples the instruction bits only in T2 and a clear request is legal at any step. The stimulus therefore changes `ir_ctl` freely on every cycle. It keeps `exec_clr` and `rst` rare, so that runs often reach T4 with opcode 3 and sometimes run through T15 and wrap.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
    localparam int SEQ_W       = 4;
    localparam int NUM_STEPS   = 1 << SEQ_W;
    localparam int OP_W        = 3;
    localparam int NUM_OPS     = 1 << OP_W;
    localparam int CTL_W       = OP_W + 1;
    localparam int MODE_POS    = CTL_W - 1;
    localparam int STEP_FETCH  = 0;
    localparam int STEP_READ   = 1;
    localparam int STEP_DECODE = 2;
    localparam int CLR_OP      = 3;
    localparam int CLR_STEP    = 4;

    typedef logic [SEQ_W-1:0] step_t;

    typedef struct packed {
        step_t sc;
    } sc_state_t;

    typedef struct packed {
        logic [NUM_OPS-1:0] dec;
        logic               mode;
    } op_state_t;

    typedef struct packed {
        logic ar_pc;
        logic mem_ir;
        logic pc_inc;
        logic ar_addr;
        logic clear;
    } strobe_t;
endpackage

// File: rtl/seq_counter.sv
module seq_counter
    import tseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    output logic [NUM_STEPS-1:0] tsig
);
    sc_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rst || clr) begin
            state_d.sc = '0;
        end else begin
            state_d.sc = state_q.sc + step_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    for (genvar g = 0; g < NUM_STEPS; g++) begin : g_tdec
        assign tsig[g] = (state_q.sc == SEQ_W'(g));
    end

    p_onehot_step_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(tsig) == 1);

    p_advance_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> tsig == {$past(tsig[NUM_STEPS-2:0]), $past(tsig[NUM_STEPS-1])});

    p_clear_to_t0_r4: assert property (@(posedge clk) disable iff (rst)
        clr |=> tsig[0]);
endmodule

// File: rtl/op_decoder.sv
module op_decoder
    import tseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [CTL_W-1:0]   ctl,
    output logic [NUM_OPS-1:0] dec,
    output logic               mode
);
    op_state_t op_d, op_q;

    always_comb begin
        op_d = op_q;
        if (rst) begin
            op_d = '0;
        end else if (load) begin
            for (int k = 0; k < NUM_OPS; k++) begin
                op_d.dec[k] = (ctl[OP_W-1:0] == OP_W'(k));
            end
            op_d.mode = ctl[MODE_POS];
        end
    end

    always_ff @(posedge clk) begin
        op_q <= op_d;
    end

    assign dec  = op_q.dec;
    assign mode = op_q.mode;

    p_dec_onehot0_r6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dec));

    p_hold_between_r6: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(dec) && $stable(mode));

    p_loaded_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        load |=> $countones(dec) == 1);
endmodule

// File: rtl/instr_timing_seq.sv
module instr_timing_seq
    import tseq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  ir_ctl,
    input  logic        exec_clr,
    output logic [15:0] t_step,
    output logic [7:0]  op_dec,
    output logic        mode_i,
    output logic        ld_ar_pc,
    output logic        rd_mem_ir,
    output logic        pc_incr,
    output logic        ld_ar_addr,
    output logic        seq_clear
);
    logic [NUM_STEPS-1:0] tsig;
    logic [NUM_OPS-1:0]   dec;
    logic                 mode;
    logic                 clr_cond;
    strobe_t              stb;

    assign clr_cond = exec_clr || (dec[CLR_OP] && tsig[CLR_STEP]);

    seq_counter u_counter (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr_cond),
        .tsig (tsig)
    );

    op_decoder u_decoder (
        .clk  (clk),
        .rst  (rst),
        .load (tsig[STEP_DECODE]),
        .ctl  (ir_ctl),
        .dec  (dec),
        .mode (mode)
    );

    always_comb begin
        stb         = '0;
        stb.ar_pc   = tsig[STEP_FETCH];
        stb.mem_ir  = tsig[STEP_READ];
        stb.pc_inc  = tsig[STEP_READ];
        stb.ar_addr = tsig[STEP_DECODE];
        stb.clear   = clr_cond;
        if (rst) begin
            stb = '0;
        end
    end

    assign t_step     = tsig;
    assign op_dec     = dec;
    assign mode_i     = mode;
    assign ld_ar_pc   = stb.ar_pc;
    assign rd_mem_ir  = stb.mem_ir;
    assign pc_incr    = stb.pc_inc;
    assign ld_ar_addr = stb.ar_addr;
    assign seq_clear  = stb.clear;

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> t_step[0] && op_dec == '0 && !mode_i);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> !(ld_ar_pc || rd_mem_ir || pc_incr || ld_ar_addr || seq_clear));

    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ld_ar_pc, rd_mem_ir, ld_ar_addr}));

    p_read_follows_r7: assert property (@(posedge clk) disable iff (rst)
        ld_ar_pc && !exec_clr |=> rd_mem_ir && pc_incr);

    p_op3_restart_r5: assert property (@(posedge clk) disable iff (rst)
        op_dec[CLR_OP] && t_step[CLR_STEP] |=> t_step[0]);

    p_clear_flag_r8: assert property (@(posedge clk) disable iff (rst)
        exec_clr |-> seq_clear);
endmodule

// File: tb/instr_timing_seq_test.sv
module instr_timing_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  ir_ctl = 4'h0;
    logic        exec_clr = 1'b0;
    logic [15:0] t_step;
    logic [7:0]  op_dec;
    logic        mode_i, ld_ar_pc, rd_mem_ir, pc_incr, ld_ar_addr, seq_clear;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;
    int   m_sc  = 0;
    logic [7:0] m_dec = 8'h00;
    logic       m_mode = 1'b0;

    always #10 clk = ~clk;

    instr_timing_seq uut (
        .clk(clk), .rst(rst), .ir_ctl(ir_ctl), .exec_clr(exec_clr),
        .t_step(t_step), .op_dec(op_dec), .mode_i(mode_i),
        .ld_ar_pc(ld_ar_pc), .rd_mem_ir(rd_mem_ir), .pc_incr(pc_incr),
        .ld_ar_addr(ld_ar_addr), .seq_clear(seq_clear)
    );

    function automatic logic [15:0] exp_t(int s);
        return 16'(1) << s;
    endfunction

    function automatic logic exp_clear(logic r, logic c, logic [7:0] d, int s);
        return !r && (c || (d[3] && s == 4));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(logic r, logic c, logic [3:0] w);
        logic clr_now;
        rst = r; exec_clr = c; ir_ctl = w;
        #1;
        check("R2", 32'(t_step), 32'(exp_t(m_sc)));
        check("R6", 32'(op_dec), 32'(m_dec));
        check("R6", 32'(mode_i), 32'(m_mode));
        check("R7", 32'(ld_ar_pc),   32'(!r && m_sc == 0));
        check("R7", 32'(rd_mem_ir),  32'(!r && m_sc == 1));
        check("R7", 32'(pc_incr),    32'(!r && m_sc == 1));
        check("R7", 32'(ld_ar_addr), 32'(!r && m_sc == 2));
        check("R8", 32'(seq_clear),  32'(exp_clear(r, c, m_dec, m_sc)));
        clr_now = exp_clear(r, c, m_dec, m_sc);
        if (r) begin
            m_sc = 0; m_dec = 8'h00; m_mode = 1'b0;
        end else begin
            if (m_sc == 2) begin
                m_dec  = 8'(1) << w[2:0];
                m_mode = w[3];
            end
            m_sc = clr_now ? 0 : (m_sc + 1) % 16;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1c5e_0b7a));
        @(negedge clk);
        step(1'b1, 1'b0, 4'h0);
        step(1'b1, 1'b1, 4'hb);
        #1;
        check("R1", 32'(t_step), 32'h1);
        check("R1", 32'(op_dec), 32'h0);
        // R3: opcode 5 never self-clears, so the count runs through T15
        for (int i = 0; i < 16; i++) step(1'b0, 1'b0, 4'h5);
        #1;
        check("R3", 32'(t_step), 32'h1);
        check("R6", 32'(op_dec), 32'h20);
        // R5: opcode 5 at T4 goes on to T5
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 4'h5);
        #1;
        check("R5", 32'(t_step), 32'h20);
        // R4: external clear from T5
        step(1'b0, 1'b1, 4'h5);
        #1;
        check("R4", 32'(t_step), 32'h1);
        // R5: opcode 3 with mode bit set clears at T4
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 4'hb);
        #1;
        check("R5", 32'(t_step), 32'h1);
        check("R6", 32'(mode_i), 32'h1);
        // R1: reset mid-cycle
        step(1'b0, 1'b0, 4'h2);
        step(1'b1, 1'b0, 4'h2);
        #1;
        check("R1", 32'(mode_i), 32'h0);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 250) == 0, ($urandom % 14) == 0, 4'($urandom));
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule